// File: doc/BRIEF.md
# Weighted Modulo 2^n+1 Adder

This block adds two operands held in plain weighted binary and returns their sum reduced modulo 2^n+1. Each operand and the result are n+1 bits wide and span the whole residue range 0 to 2^n, so the block can sit in a residue-arithmetic channel without any converters on its inputs or output.

The datapath has three stages. First, a carry-save stage folds the removal of the modulus into a constant that depends only on the two operand top bits. It reduces the sum to two n-bit vectors, and the top carry re-enters inverted at bit 0. Second, a diminished-1 style parallel-prefix core adds the two vectors, with the inverted group carry fed back as a re-entering carry. Third, a one-gate correction forms the top result bit, which covers the case where the residue equals 2^n.

Zero operands and zero sums need no detection logic. An optional output register adds one clock of latency.

Top module: `wmod_adder`

## Requirements
- R1: For any operands a and b in 0..2^N, the result equals (a+b) mod (2^N+1).
- R2: The result is always in 0..2^N. When the residue is exactly 2^N, the output is bit N set and all lower bits clear, for example a=2^N, b=0 or a=3, b=2^N-3.
- R3: Zero cases give 0: a=b=0, a=2^N with b=1, and a=2^(N-1) with b=2^(N-1)+1. In each case the sum equals 0 or 2^N+1.
- R4: a=b=2^N gives 2^N-1.
- R5: With the output register enabled (REG_OUT=1, the default), s shows the result for the operands present at the previous rising clock edge.
- R6: While rst_n is low, s is 0, and it clears at once when rst_n falls.
- R7: The same function holds for every N from 4 to 16. This is exercised at N=4, 5, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, clears s |
| a | input | N+1 | First operand, 0..2^N |
| b | input | N+1 | Second operand, 0..2^N |
| s | output | N+1 | Residue (a+b) mod (2^N+1), registered when REG_OUT=1 |

## Verification
The block keeps no state apart from the output register, so any fault in the carry-save constant, the prefix tree or the re-entering carry shows up as a wrong residue one clock after the operands that expose it. A fault in the end-around carry mostly hits pairs whose sum crosses 2^N. A fault in the top-bit correction appears only when the residue is exactly 2^N. For this reason every operand pair is applied at N=4 and N=5, and the corner sums are applied at every width.

// File: rtl/wmod_pkg.sv
package wmod_pkg;
  // number of prefix combine levels for an n-bit core
  function automatic int wm_levels(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // modulus 2^n+1 as an integer
  function automatic int wm_modulus(input int n);
    return (1 << n) + 1;
  endfunction
endpackage

// File: rtl/wmod_csa.sv
module wmod_csa
  import wmod_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N:0]   a,
  input  logic [N:0]   b,
  output logic [N-1:0] y,
  output logic [N-1:0] u
);
  localparam int MODI = wm_modulus(N);

  logic [N-1:0] hi_cnt;
  logic [N-1:0] kconst;
  logic [N-1:0] sum_v;
  logic [N-1:0] cy_v;

  // constant = -(2 + a[N] + b[N]) mod 2^N+1, i.e. the complement of the top-bit count
  always_comb begin
    hi_cnt    = '0;
    hi_cnt[0] = a[N] ^ b[N];
    hi_cnt[1] = a[N] & b[N];
    kconst    = ~hi_cnt;
  end

  always_comb begin
    sum_v = a[N-1:0] ^ b[N-1:0] ^ kconst;
    cy_v  = (a[N-1:0] & b[N-1:0]) | (a[N-1:0] & kconst) | (b[N-1:0] & kconst);
  end

  // top carry re-enters inverted at bit 0
  assign y = sum_v;
  assign u = {cy_v[N-2:0], ~cy_v[N-1]};

  // the vector pair is congruent to a+b-1
  always_comb begin
    if (int'(a) <= (1 << N) && int'(b) <= (1 << N))
      assert_csa_congruent_R1: assert (((int'(y) + int'(u)) % MODI) ==
                                       ((int'(a) + int'(b) + MODI - 1) % MODI));
  end
endmodule

// File: rtl/wmod_prefix.sv
module wmod_prefix
  import wmod_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] y,
  input  logic [N-1:0] u,
  output logic [N:0]   w
);
  localparam int L = wm_levels(N);

  logic [N-1:0] gv [0:L];
  logic [N-1:0] pv [0:L];
  logic [N-1:0] cv;
  logic         eac;

  assign gv[0] = y & u;
  assign pv[0] = y ^ u;

  // Sklansky tree: the upper half of each block takes the top of the lower half
  for (genvar lv = 0; lv < L; lv++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (((i >> lv) & 1) == 1) begin : g_cmb
        localparam int J = ((i >> lv) << lv) - 1;
        assign gv[lv+1][i] = gv[lv][i] | (pv[lv][i] & gv[lv][J]);
        assign pv[lv+1][i] = pv[lv][i] & pv[lv][J];
      end else begin : g_pas
        assign gv[lv+1][i] = gv[lv][i];
        assign pv[lv+1][i] = pv[lv][i];
      end
    end
  end

  // inverted end-around carry re-enters through the group propagate terms
  assign eac = ~gv[L][N-1];
  assign cv  = gv[L] | (pv[L] & {N{eac}});

  always_comb begin
    w[0]     = pv[0][0] ^ eac;
    w[N-1:1] = pv[0][N-1:1] ^ cv[N-2:0];
    w[N]     = eac & pv[L][N-1];
  end

  always_comb begin
    assert_eac_R1: assert (eac == ((int'(y) + int'(u)) < (1 << N)));
    if (w[N])
      assert_topbit_R2: assert (w[N-1:0] == '0);
  end
endmodule

// File: rtl/wmod_adder.sv
module wmod_adder
  import wmod_pkg::*;
#(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N:0]   a,
  input  logic [N:0]   b,
  output logic [N:0]   s
);
  localparam int MODI = wm_modulus(N);
  localparam int TOPV = 1 << N;

  logic [N-1:0] y_v;
  logic [N-1:0] u_v;
  logic [N:0]   s_nxt;

  wmod_csa #(.N(N)) u_csa (
    .a (a),
    .b (b),
    .y (y_v),
    .u (u_v)
  );

  wmod_prefix #(.N(N)) u_pfx (
    .y (y_v),
    .u (u_v),
    .w (s_nxt)
  );

  if (REG_OUT) begin : g_reg
    logic [N:0] s_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_q <= '0;
      else        s_q <= s_nxt;
    end

    assign s = s_q;

    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(s) <= TOPV);

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && int'($past(a)) <= TOPV && int'($past(b)) <= TOPV) |->
        (int'(s) == ((int'($past(a)) + int'($past(b))) % MODI)));

    always @(posedge clk) begin
      if (!rst_n) assert_reset_R6: assert (s == '0);
    end
  end else begin : g_comb
    assign s = s_nxt;
  end
endmodule

// File: tb/sim_wmod_adder.sv
`timescale 1ns/1ps
module sim_wmod_adder;
  logic clk = 1'b0;
  logic rst_n;
  logic [8:0]  a0, b0;   wire [8:0]  s0;
  logic [4:0]  a4, b4;   wire [4:0]  s4;
  logic [5:0]  a5, b5;   wire [5:0]  s5;
  logic [16:0] a16, b16; wire [16:0] s16;

  int n_chk = 0;
  int n_fail = 0;
  int    q0[$], q4[$], q5[$], q16[$];
  string r0[$], r4[$], r5[$], r16[$];

  always #2 clk = ~clk;

  wmod_adder #(.N(8))  u0   (.clk(clk), .rst_n(rst_n), .a(a0),  .b(b0),  .s(s0));
  wmod_adder #(.N(4))  u_n4 (.clk(clk), .rst_n(rst_n), .a(a4),  .b(b4),  .s(s4));
  wmod_adder #(.N(5))  u_n5 (.clk(clk), .rst_n(rst_n), .a(a5),  .b(b5),  .s(s5));
  wmod_adder #(.N(16)) u_n16(.clk(clk), .rst_n(rst_n), .a(a16), .b(b16), .s(s16));

  function automatic int rmod(int x, int z, int n);
    return (x + z) % ((1 << n) + 1);
  endfunction

  function automatic int corner_a(int k, int n);
    case (k)
      0: return 0;
      1: return 1 << n;
      2: return 1 << n;
      3: return 1 << (n - 1);
      4: return 3;
      5: return 1 << n;
      6: return 0;
      default: return 1 << n;
    endcase
  endfunction

  function automatic int corner_b(int k, int n);
    case (k)
      0: return 0;
      1: return 1 << n;
      2: return 1;
      3: return (1 << (n - 1)) + 1;
      4: return (1 << n) - 3;
      5: return 0;
      6: return 1;
      default: return (1 << n) - 1;
    endcase
  endfunction

  function automatic string corner_req(int k);
    case (k)
      0, 2, 3: return "R3 R5";
      1:       return "R4 R5";
      4, 5:    return "R2 R5";
      default: return "R1 R5";
    endcase
  endfunction

  task automatic check(string req, string who, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, who, got, exp);
    end
  endtask

  task automatic check_all_zero(string req);
    check(req, "n8",  int'(s0),  0);
    check(req, "n4",  int'(s4),  0);
    check(req, "n5",  int'(s5),  0);
    check(req, "n16", int'(s16), 0);
  endtask

  task automatic check_queued();
    check(r0.pop_front(),  "n8",  int'(s0),  q0.pop_front());
    check(r4.pop_front(),  "n4",  int'(s4),  q4.pop_front());
    check(r5.pop_front(),  "n5",  int'(s5),  q5.pop_front());
    check(r16.pop_front(), "n16", int'(s16), q16.pop_front());
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, R1 to R7 not completed");
    finish_run();
  end

  initial begin
    int x, z;
    rst_n = 1'b0;
    a0 = '0; b0 = '0; a4 = '0; b4 = '0; a5 = '0; b5 = '0; a16 = '0; b16 = '0;
    // R6: output held at zero during reset
    repeat (3) begin
      @(negedge clk);
      check_all_zero("R6");
    end
    for (int cyc = 0; cyc < 8 + 1089; cyc++) begin
      @(negedge clk);
      if (cyc == 0) rst_n = 1'b1;
      else check_queued();
      if (cyc < 8) begin
        a0  = 9'(corner_a(cyc, 8));   b0  = 9'(corner_b(cyc, 8));
        a4  = 5'(corner_a(cyc, 4));   b4  = 5'(corner_b(cyc, 4));
        a5  = 6'(corner_a(cyc, 5));   b5  = 6'(corner_b(cyc, 5));
        a16 = 17'(corner_a(cyc, 16)); b16 = 17'(corner_b(cyc, 16));
        r0.push_back(corner_req(cyc));  r4.push_back(corner_req(cyc));
        r5.push_back(corner_req(cyc));  r16.push_back(corner_req(cyc));
      end else begin
        x = cyc - 8;
        a5 = 6'(x / 33);          b5 = 6'(x % 33);
        z = x % 289;
        a4 = 5'(z / 17);          b4 = 5'(z % 17);
        a0  = 9'($urandom_range(256, 0));
        b0  = 9'($urandom_range(256, 0));
        a16 = 17'($urandom_range(65536, 0));
        b16 = 17'($urandom_range(65536, 0));
        r0.push_back("R1 R5");  r4.push_back("R1 R7");
        r5.push_back("R1 R7");  r16.push_back("R1 R7");
      end
      q0.push_back(rmod(int'(a0), int'(b0), 8));
      q4.push_back(rmod(int'(a4), int'(b4), 4));
      q5.push_back(rmod(int'(a5), int'(b5), 5));
      q16.push_back(rmod(int'(a16), int'(b16), 16));
    end
    @(negedge clk);
    check_queued();
    // R6: asynchronous clear with nonzero operands applied
    a0 = 9'd200; b0 = 9'd30; a4 = 5'd7; b4 = 5'd5; a5 = 6'd9; b5 = 6'd4;
    a16 = 17'd1000; b16 = 17'd7;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_all_zero("R6");
    finish_run();
  end
endmodule